// File: doc/BRIEF.md
# USB device interrupt status register

This block holds the interrupt status of a small full-speed USB device controller and contains the logic that detects bus suspend and wake-up. The protocol engine sends it one-cycle event pulses (correct SETUP received, correct non-SETUP transfer, error, bus reset, start of frame). The endpoint logic sends it the levels of its per-endpoint correct-transfer flags. The transceiver side provides the sampled line idle state. Software sees one 8-bit status word that it can read and write, and the block drives two interrupt request lines from it.

Hardware sets the flags and software clears them. Software cannot set a flag. A write clears each flag whose written bit is zero. The top bit of the word is not stored: it reports the pending endpoint transfer flags, and software clears it only by clearing those flags in the endpoint logic. A SETUP that completes while endpoint 0 still has an unserviced transfer is reported as an overrun. The block also withholds the load strobe for the transfer detail register in that case.

Suspend is detected with an idle counter that a bus reset arms. A forced suspend disarms it, and it stays disarmed until resume completes. While the device is suspended, any line activity raises a wake flag. The wake flag has its own interrupt line.

Top module: `usbd_irq_status`

## Requirements
- R1: After reset the status word reads 0x00, and `irq` and `wake_irq` are low.
- R2: Bit positions in `reg_rdata`: 7 correct transfer, 6 reserved, 5 SETUP overrun, 4 error, 3 suspend, 2 wake, 1 bus reset, 0 start of frame. Bit 6 always reads 0. Writes to bits 7 and 6 have no effect.
- R3: Bit 7 is the OR of all bits of `ep_ctr_flags`, with the same cycle's value: bit 0 is endpoint 0, and bits 1 to 4 are the receive and transmit flags of endpoints 1 and 2. No write clears bit 7.
- R4: `setup_done` while `ep_ctr_flags[0]` is 1 sets bit 5 at the next edge and holds `info_load` low in that cycle. Otherwise `info_load` is high in any cycle with `setup_done` or `xfer_done`.
- R5: A pulse on `err_evt`, `bus_reset_evt` or `sof_evt` sets bit 4, 1 or 0 at the next edge, and the bit stays set until software clears it.
- R6: A write with `reg_we` clears each stored flag (bits 5 to 0) whose written bit is 0 and leaves unchanged each flag whose written bit is 1.
- R7: If a flag's set event and a write clearing it occur in the same cycle, the flag ends up set.
- R8: While the detector is armed, bit 3 is set at the edge that completes `IDLE_LIMIT` consecutive cycles of `line_idle` high. Any cycle with `line_idle` low restarts the count. The bit fires only once per idle period.
- R9: The detector is disarmed after reset. `bus_reset_evt` or `resume_done` arms it. `force_suspend` disarms it, and it stays disarmed after `force_suspend` drops until `resume_done` or a bus reset.
- R10: The device counts as suspended after a detected suspend or while `force_suspend` is high. In that state, a cycle with `line_idle` low (and `force_suspend` low) sets bit 2 and ends the suspended state.
- R11: `irq` is the OR of bits 7, 5, 4, 3, 1 and 0. `wake_irq` equals bit 2, and bit 2 alone does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_ctr_flags | input | NUM_CTR (5) | Pending correct-transfer flag levels from the endpoints, bit 0 = endpoint 0 |
| setup_done | input | 1 | Pulse: correct SETUP transfer on endpoint 0 |
| xfer_done | input | 1 | Pulse: correct non-SETUP transfer |
| err_evt | input | 1 | Pulse: timeout, CRC, stuffing, framing or overrun error |
| bus_reset_evt | input | 1 | Pulse: USB reset seen on the bus |
| sof_evt | input | 1 | Pulse: start-of-frame token received |
| line_idle | input | 1 | Sampled line is in the idle state |
| force_suspend | input | 1 | Software-forced suspend level |
| resume_done | input | 1 | Pulse: resume sequence finished |
| reg_we | input | 1 | Write strobe for the status word |
| reg_wdata | input | 8 | Write data: 0 clears a flag, 1 keeps it |
| reg_rdata | output | 8 | Status word |
| irq | output | 1 | Main interrupt request |
| wake_irq | output | 1 | Wake interrupt request |
| info_load | output | 1 | Load strobe for the transfer detail register |

## Verification
The bench fires a start-of-frame pulse in the same cycle as a write of all zeros. A design that let the clear win would lose that event. The bench writes zeros and all ones while endpoint flags are pending, to catch a design that stores the correct-transfer bit and then drops it or lets it stick, or that lets the reserved bit read back. It breaks an idle run one cycle short of the limit and then counts exactly the limit. An off-by-one counter would report suspend one cycle early or late, and a counter that is not restarted would report it too soon. It also drops forced suspend and leaves the line idle well past the limit, which exposes a detector that re-arms before resume has finished.

// File: rtl/usbd_irq_pkg.sv
package usbd_irq_pkg;

    // Bit positions in the status word; software decodes these.
    localparam int BIT_SOF   = 0;
    localparam int BIT_BRST  = 1;
    localparam int BIT_WAKE  = 2;
    localparam int BIT_SUSP  = 3;
    localparam int BIT_ERR   = 4;
    localparam int BIT_SOVR  = 5;
    localparam int BIT_RSVD  = 6;
    localparam int BIT_CTR   = 7;

    localparam int NUM_STORED = 6;

    // Stored flags, packed so that bit i lands on status bit i.
    typedef struct packed {
        logic sovr;
        logic err;
        logic susp;
        logic wake;
        logic brst;
        logic sof;
    } flag_vec_t;

    function automatic logic [7:0] pack_status(input logic ctr, input flag_vec_t f);
        pack_status = {ctr, 1'b0, f};
    endfunction

    function automatic logic main_irq(input logic ctr, input flag_vec_t f);
        main_irq = ctr | f.sovr | f.err | f.susp | f.brst | f.sof;
    endfunction

endpackage

// File: rtl/usbd_flag_bank.sv
module usbd_flag_bank #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_evt,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_keep,
    output logic [WIDTH-1:0] flags
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_flag
        logic q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= 1'b0;
            end else if (set_evt[i]) begin
                q <= 1'b1;                 // set beats a same-cycle clear
            end else if (wr_en && !wr_keep[i]) begin
                q <= 1'b0;
            end
        end
        assign flags[i] = q;
    end

endmodule

// File: rtl/usbd_ctr_merge.sv
module usbd_ctr_merge #(
    parameter int NUM_CTR = 5
) (
    input  logic [NUM_CTR-1:0] ep_ctr_flags,
    input  logic               setup_done,
    input  logic               xfer_done,
    output logic               ctr_any,
    output logic               sovr_evt,
    output logic               info_load
);

    logic ep0_pending;

    assign ep0_pending = ep_ctr_flags[0];
    assign ctr_any     = |ep_ctr_flags;
    assign sovr_evt    = setup_done & ep0_pending;
    assign info_load   = xfer_done | (setup_done & ~ep0_pending);

endmodule

// File: rtl/usbd_idle_monitor.sv
module usbd_idle_monitor #(
    parameter int IDLE_LIMIT = 144000
) (
    input  logic clk,
    input  logic rst,
    input  logic line_idle,
    input  logic bus_reset_evt,
    input  logic force_suspend,
    input  logic resume_done,
    output logic susp_evt,
    output logic wake_evt
);

    localparam int CNT_W = $clog2(IDLE_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_LIMIT - 1);
    localparam logic [CNT_W-1:0] SAT  = CNT_W'(IDLE_LIMIT);

    logic             armed;
    logic             in_susp;
    logic [CNT_W-1:0] cnt;

    assign susp_evt = armed & line_idle & (cnt == LAST);
    assign wake_evt = in_susp & ~line_idle & ~force_suspend;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (force_suspend) begin
            armed <= 1'b0;
        end else if (bus_reset_evt || resume_done) begin
            armed <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !armed || !line_idle) begin
            cnt <= '0;
        end else if (cnt != SAT) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_susp <= 1'b0;
        end else if (force_suspend) begin
            in_susp <= 1'b1;
        end else if (wake_evt) begin
            in_susp <= 1'b0;
        end else if (susp_evt) begin
            in_susp <= 1'b1;
        end
    end

endmodule

// File: rtl/usbd_irq_status.sv
module usbd_irq_status
    import usbd_irq_pkg::*;
#(
    parameter int NUM_EP     = 3,
    parameter int IDLE_LIMIT = 144000,
    localparam int NUM_CTR   = 1 + 2 * (NUM_EP - 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CTR-1:0] ep_ctr_flags,
    input  logic               setup_done,
    input  logic               xfer_done,
    input  logic               err_evt,
    input  logic               bus_reset_evt,
    input  logic               sof_evt,
    input  logic               line_idle,
    input  logic               force_suspend,
    input  logic               resume_done,
    input  logic               reg_we,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic               irq,
    output logic               wake_irq,
    output logic               info_load
);

    logic      ctr_any;
    logic      sovr_evt;
    logic      susp_evt;
    logic      wake_evt;
    flag_vec_t set_vec;
    flag_vec_t flags;
    logic [NUM_STORED-1:0] keep_bits;

    usbd_ctr_merge #(.NUM_CTR(NUM_CTR)) u_ctr (
        .ep_ctr_flags (ep_ctr_flags),
        .setup_done   (setup_done),
        .xfer_done    (xfer_done),
        .ctr_any      (ctr_any),
        .sovr_evt     (sovr_evt),
        .info_load    (info_load)
    );

    usbd_idle_monitor #(.IDLE_LIMIT(IDLE_LIMIT)) u_idle (
        .clk           (clk),
        .rst           (rst),
        .line_idle     (line_idle),
        .bus_reset_evt (bus_reset_evt),
        .force_suspend (force_suspend),
        .resume_done   (resume_done),
        .susp_evt      (susp_evt),
        .wake_evt      (wake_evt)
    );

    always_comb begin
        set_vec      = '0;
        set_vec.sovr = sovr_evt;
        set_vec.err  = err_evt;
        set_vec.susp = susp_evt;
        set_vec.wake = wake_evt;
        set_vec.brst = bus_reset_evt;
        set_vec.sof  = sof_evt;
    end

    // Bits 7 and 6 of the write data are deliberately not connected.
    assign keep_bits = reg_wdata[NUM_STORED-1:0];

    usbd_flag_bank #(.WIDTH(NUM_STORED)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_evt (set_vec),
        .wr_en   (reg_we),
        .wr_keep (keep_bits),
        .flags   (flags)
    );

    assign reg_rdata = pack_status(ctr_any, flags);
    assign irq       = main_irq(ctr_any, flags);
    assign wake_irq  = flags.wake;

endmodule

// File: rtl/usbd_irq_status_chk.sv
module usbd_irq_status_chk #(
    parameter int NUM_CTR = 5
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_CTR-1:0] ep_ctr_flags,
    input logic               setup_done,
    input logic               sof_evt,
    input logic               bus_reset_evt,
    input logic               reg_we,
    input logic [1:0]         wr_low,
    input logic [7:0]         reg_rdata,
    input logic               irq,
    input logic               wake_irq,
    input logic               info_load
);

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst) reg_rdata[6] == 1'b0);

    // R3
    ctr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ep_ctr_flags == '0) |-> (reg_rdata[7] == 1'b0));

    // R4
    sovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (setup_done && ep_ctr_flags[0]) |=> reg_rdata[5]);

    // R4
    sovr_noload_chk: assert property (@(posedge clk) disable iff (rst)
        (setup_done && ep_ctr_flags[0]) |-> !info_load);

    // R7
    sof_wins_chk: assert property (@(posedge clk) disable iff (rst)
        sof_evt |=> reg_rdata[0]);

    // R6
    brst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !wr_low[1] && !bus_reset_evt) |=> !reg_rdata[1]);

    // R6
    sof_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && wr_low[0] && reg_rdata[0]) |=> reg_rdata[0]);

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((reg_rdata & 8'hBB) == 8'h00) |-> !irq);

    // R11
    wake_line_chk: assert property (@(posedge clk) disable iff (rst)
        wake_irq |-> reg_rdata[2]);

endmodule

bind usbd_irq_status usbd_irq_status_chk #(.NUM_CTR(NUM_CTR)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ep_ctr_flags  (ep_ctr_flags),
    .setup_done    (setup_done),
    .sof_evt       (sof_evt),
    .bus_reset_evt (bus_reset_evt),
    .reg_we        (reg_we),
    .wr_low        (reg_wdata[1:0]),
    .reg_rdata     (reg_rdata),
    .irq           (irq),
    .wake_irq      (wake_irq),
    .info_load     (info_load)
);

// File: tb/usbd_irq_status_tb_top.sv
module usbd_irq_status_tb_top;

    localparam int LIMIT = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] ep_ctr_flags = '0;
    logic       setup_done = 1'b0, xfer_done = 1'b0, err_evt = 1'b0;
    logic       bus_reset_evt = 1'b0, sof_evt = 1'b0, line_idle = 1'b0;
    logic       force_suspend = 1'b0, resume_done = 1'b0, reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, wake_irq, info_load;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    usbd_irq_status #(.NUM_EP(3), .IDLE_LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst(rst), .ep_ctr_flags(ep_ctr_flags),
        .setup_done(setup_done), .xfer_done(xfer_done), .err_evt(err_evt),
        .bus_reset_evt(bus_reset_evt), .sof_evt(sof_evt), .line_idle(line_idle),
        .force_suspend(force_suspend), .resume_done(resume_done),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .wake_irq(wake_irq), .info_load(info_load)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        reg_we = 1'b1; reg_wdata = d;
        tick();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic t_reset();
        rst = 1'b1; line_idle = 1'b0;
        tick(3);
        rst = 1'b0;
        tick();
        chk("R1 status", reg_rdata, 8'h00);
        chk("R1 irq", {6'd0, wake_irq, irq}, 8'h00);
    endtask

    task automatic t_events();
        sof_evt = 1'b1; tick(); sof_evt = 1'b0;
        chk("R5 sof", reg_rdata, 8'h01);
        chk("R11 irq on sof", {7'd0, irq}, 8'h01);
        err_evt = 1'b1; tick(); err_evt = 1'b0;
        bus_reset_evt = 1'b1; tick(); bus_reset_evt = 1'b0;
        tick(3);
        chk("R5 sticky err/reset/sof", reg_rdata, 8'h13);
        wr(8'hFE);
        chk("R6 clear bit0 keep others", reg_rdata, 8'h12);
        wr(8'h00);
        chk("R6 clear all", reg_rdata, 8'h00);
    endtask

    task automatic t_set_wins();
        sof_evt = 1'b1; reg_we = 1'b1; reg_wdata = 8'h00;
        tick();
        sof_evt = 1'b0; reg_we = 1'b0;
        chk("R7 set beats clear", reg_rdata, 8'h01);
        wr(8'h00);
    endtask

    task automatic t_ctr();
        ep_ctr_flags = 5'b00100; #1;
        chk("R3 ctr from ep flag", reg_rdata, 8'h80);
        chk("R11 irq on ctr", {7'd0, irq}, 8'h01);
        wr(8'h00);
        chk("R3 ctr not cleared by write", reg_rdata, 8'h80);
        wr(8'hFF);
        chk("R2 reserved reads 0, no set", reg_rdata, 8'h80);
        ep_ctr_flags = 5'b00000; #1;
        chk("R3 ctr drops with ep flags", reg_rdata, 8'h00);
    endtask

    task automatic t_sovr();
        ep_ctr_flags = 5'b00001; setup_done = 1'b1; #1;
        chk("R4 no info_load on overrun", {7'd0, info_load}, 8'h00);
        tick();
        setup_done = 1'b0;
        chk("R4 sovr set", reg_rdata, 8'hA0);
        ep_ctr_flags = 5'b00000; setup_done = 1'b1; #1;
        chk("R4 info_load on normal setup", {7'd0, info_load}, 8'h01);
        tick();
        setup_done = 1'b0; xfer_done = 1'b1; #1;
        chk("R4 info_load on transfer", {7'd0, info_load}, 8'h01);
        xfer_done = 1'b0;
        chk("R4 sovr only on overrun", reg_rdata, 8'h20);
        wr(8'h00);
    endtask

    task automatic t_suspend();
        line_idle = 1'b1; tick(10);
        line_idle = 1'b0; tick();
        line_idle = 1'b1; tick(LIMIT - 1);
        chk("R8 restart, one short", reg_rdata, 8'h00);
        tick();
        chk("R8 suspend at limit", reg_rdata, 8'h08);
        wr(8'h00);
        tick(5);
        chk("R8 fires once per idle period", reg_rdata, 8'h00);
    endtask

    task automatic t_wake();
        line_idle = 1'b0; tick();
        chk("R10 wake flag", reg_rdata, 8'h04);
        chk("R11 wake only on wake_irq", {6'd0, wake_irq, irq}, 8'h02);
        wr(8'h00);
    endtask

    task automatic t_force();
        force_suspend = 1'b1; tick(); force_suspend = 1'b0;
        line_idle = 1'b1; tick(LIMIT + 10);
        chk("R9 disarmed after force", reg_rdata, 8'h00);
        line_idle = 1'b0; tick();
        chk("R10 wake from forced suspend", reg_rdata, 8'h04);
        wr(8'h00);
        resume_done = 1'b1; tick(); resume_done = 1'b0;
        line_idle = 1'b1; tick(LIMIT);
        chk("R9 rearmed by resume", reg_rdata, 8'h08);
        wr(8'h00);
    endtask

    task automatic t_disarmed_at_reset();
        rst = 1'b1; line_idle = 1'b0; tick(2); rst = 1'b0;
        line_idle = 1'b1; tick(LIMIT + 10);
        chk("R9 disarmed after reset", reg_rdata, 8'h00);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_events();
        t_set_wins();
        t_ctr();
        t_sovr();
        t_suspend();
        t_wake();
        t_force();
        t_disarmed_at_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule